// File: doc/BRIEF.md
# Serial Gain-Word Control Front End

This block is the digital control front end of a programmable-gain line driver. A host loads an 8-bit gain word over a three-wire serial port made of a data line, a serial clock and a load-enable. The word goes into a shift register. The active gain code is held in a separate latch, and that latch changes only when load-enable rises. The same rising edge freezes the shift register until load-enable falls again. Each code step is 1 dB, and the usable gain spans 59 dB.

All five pins are oversampled by a fast system clock, which must run at least four times the serial clock rate. Every pin passes through a two-flop synchronizer, and edges are detected in the system clock domain. A serial bit is taken into a master stage on the rising serial clock edge. It moves into the shift register on the falling edge, so the word enters most significant bit first.

Beside the gain path, a mode decoder combines the power-up pin and the transmit-enable pin into one of three states:
- active
- transmit-disabled, which keeps the output termination
- sleep, which drives the output to high impedance

The block reports the committed gain code, the matching attenuation in dB below full gain, and the three mode flags with a high-impedance indicator.

Top module: `gain_ctl_if`

## Requirements
- R1: After reset, gain_code is 0, atten_db is 59 and st_txoff is the only mode flag set.
- R2: Serial bits on sdin are taken on a sclk rising edge and moved into the shift register on the following falling edge. They enter MSB first, and the last 8 bits shifted before a commit form the word.
- R3: While ld_en stays low, gain_code keeps its value whatever happens on sclk and sdin.
- R4: A low-to-high transition of ld_en copies the shift register into the gain latch. The gain_code output updates within a few system clocks.
- R5: While ld_en is high, sclk pulses do not alter the shift register. A later ld_en fall followed by a rise with no sclk activity commits the previously loaded word again.
- R6: A committed word above 59 is stored as 59.
- R7: atten_db always equals 59 minus gain_code.
- R8: When pwr_up is low, st_sleep and out_hiz are set and the other mode flags are clear, whatever the level of tx_en.
- R9: When pwr_up is high, tx_en low gives st_txoff with out_hiz clear, and tx_en high gives st_active.
- R10: The gain code is retained through sleep and transmit-disable.
- R11: Exactly one of st_active, st_txoff and st_sleep is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data, MSB first |
| ld_en | input | 1 | Load-enable: low shifts, rising edge commits |
| tx_en | input | 1 | Transmit enable, high to transmit |
| pwr_up | input | 1 | High powers up, low selects sleep |
| gain_code | output | 8 | Committed gain code, 0 to 59 |
| atten_db | output | 8 | Attenuation below full gain in dB |
| st_active | output | 1 | Normal transmission mode |
| st_txoff | output | 1 | Transmit-disabled mode |
| st_sleep | output | 1 | Sleep / power-down mode |
| out_hiz | output | 1 | Output driven to high impedance |

## Verification
The hardest state to reach from the ports is a shift register that holds a stale word after ld_en has fallen. This is needed to show that clocking while ld_en is high really changed nothing. To reach it, the stimulus commits a known word and then pulses sclk with different data while ld_en is high. It then drops ld_en and raises it again with no clocks in between, so the commit shows the frozen contents at gain_code. Random words, including values above 59 and words longer than eight bits, are mixed with these directed sequences and with walks through all four mode pin combinations.

// File: rtl/gain_ctl_if.sv
module gain_ctl_if #(
  parameter int WORD_W   = 8,
  parameter int GAIN_MAX = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              ld_en,
  input  logic              tx_en,
  input  logic              pwr_up,
  output logic [WORD_W-1:0] gain_code,
  output logic [WORD_W-1:0] atten_db,
  output logic              st_active,
  output logic              st_txoff,
  output logic              st_sleep,
  output logic              out_hiz
);
  localparam logic [4:0]        SYNC_INIT = 5'b10000;
  localparam logic [WORD_W-1:0] TOP_CODE  = WORD_W'(GAIN_MAX);

  logic [4:0]        s1, s2;
  logic              sclk_d, ld_d, master;
  logic [WORD_W-1:0] shreg;

  wire [4:0] raw    = {pwr_up, tx_en, ld_en, sdin, sclk};
  wire sclk_s       = s2[0];
  wire sdin_s       = s2[1];
  wire ld_s         = s2[2];
  wire tx_s         = s2[3];
  wire pwr_s        = s2[4];
  wire sclk_rise    = sclk_s & ~sclk_d;
  wire sclk_fall    = ~sclk_s & sclk_d;
  wire ld_rise      = ld_s & ~ld_d;
  wire [WORD_W-1:0] clamped = (shreg > TOP_CODE) ? TOP_CODE : shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= SYNC_INIT;
      s2     <= SYNC_INIT;
      sclk_d <= 1'b0;
      ld_d   <= 1'b0;
    end else begin
      s1     <= raw;
      s2     <= s1;
      sclk_d <= sclk_s;
      ld_d   <= ld_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master <= 1'b0;
      shreg  <= '0;
    end else if (!ld_s) begin
      if (sclk_rise) master <= sdin_s;
      if (sclk_fall) shreg  <= {shreg[WORD_W-2:0], master};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_code <= '0;
    else if (ld_rise) gain_code <= clamped;
  end

  assign atten_db = TOP_CODE - gain_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sleep  <= 1'b0;
      st_txoff  <= 1'b1;
      st_active <= 1'b0;
    end else begin
      st_sleep  <= ~pwr_s;
      st_txoff  <= pwr_s & ~tx_s;
      st_active <= pwr_s & tx_s;
    end
  end

  assign out_hiz = st_sleep;
endmodule

// File: rtl/gain_ctl_if_chk.sv
module gain_ctl_if_chk #(
  parameter int WORD_W   = 8,
  parameter int GAIN_MAX = 59
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] gain_code,
  input logic [WORD_W-1:0] shreg,
  input logic              ld_s,
  input logic              ld_rise,
  input logic              pwr_s,
  input logic              st_active,
  input logic              st_txoff,
  input logic              st_sleep,
  input logic              out_hiz
);
  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code <= WORD_W'(GAIN_MAX)); // R6
  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable(gain_code)); // R3
  AST_SHIFT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ld_s |=> $stable(shreg)); // R5
  AST_SLEEP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_s |=> (st_sleep && out_hiz && !st_txoff && !st_active)); // R8
  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_active, st_txoff, st_sleep}) == 1); // R11
endmodule

bind gain_ctl_if gain_ctl_if_chk #(.WORD_W(WORD_W), .GAIN_MAX(GAIN_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .gain_code(gain_code), .shreg(shreg),
  .ld_s(ld_s), .ld_rise(ld_rise), .pwr_s(pwr_s), .st_active(st_active),
  .st_txoff(st_txoff), .st_sleep(st_sleep), .out_hiz(out_hiz));

// File: tb/test_gain_ctl_if.sv
module test_gain_ctl_if;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdin = 0, ld_en = 0, tx_en = 0, pwr_up = 1;
  logic [7:0] gain_code, atten_db;
  logic st_active, st_txoff, st_sleep, out_hiz;
  int checks = 0, failures = 0;
  int exp_gain = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gain_ctl_if i_gain_ctl_if (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .ld_en(ld_en),
    .tx_en(tx_en), .pwr_up(pwr_up), .gain_code(gain_code), .atten_db(atten_db),
    .st_active(st_active), .st_txoff(st_txoff), .st_sleep(st_sleep), .out_hiz(out_hiz));

  function automatic int clamp59(int w);
    return (w > 59) ? 59 : w;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [15:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = w[i];
      wait_cyc(4);
      sclk = 1;
      wait_cyc(4);
      sclk = 0;
      wait_cyc(4);
    end
  endtask

  task automatic commit();
    ld_en = 1;
    wait_cyc(8);
    ld_en = 0;
    wait_cyc(8);
  endtask

  task automatic check_gain(string req);
    chk(req, gain_code, exp_gain);
    chk("R7", atten_db, 59 - exp_gain);
  endtask

  task automatic check_mode(string req, bit a, bit t, bit s);
    wait_cyc(8);
    chk(req, {st_active, st_txoff, st_sleep, out_hiz}, {a, t, s, s});
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5A17);
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1", gain_code, 0);
    chk("R1", atten_db, 59);
    chk("R1", {st_active, st_txoff, st_sleep}, 3'b010);

    // R2/R4: directed word, MSB first
    shift_bits(16'h0025, 8);
    chk("R3", gain_code, 0);
    commit();
    exp_gain = 37;
    check_gain("R4");

    // R6: above the range and the all-ones word
    shift_bits(16'h003C, 8); commit(); exp_gain = 59; check_gain("R6");
    shift_bits(16'h00FF, 8); commit(); exp_gain = 59; check_gain("R6");
    shift_bits(16'h003B, 8); commit(); exp_gain = 59; check_gain("R6");

    // R2: longer stream, only last eight bits count
    shift_bits(16'hA513, 12); commit(); exp_gain = 'h13 == 19 ? 49 : 0;
    exp_gain = clamp59(16'hA513 & 16'h00FF) ; check_gain("R2");

    // R5: clocks while ld_en high do not reach the register
    shift_bits(16'h000A, 8);
    ld_en = 1; wait_cyc(8);
    exp_gain = 10; check_gain("R4");
    shift_bits(16'h0033, 8);
    ld_en = 0; wait_cyc(8);
    ld_en = 1; wait_cyc(8);
    check_gain("R5");
    ld_en = 0; wait_cyc(8);

    // R3: shifting with ld_en low leaves gain alone
    shift_bits(16'h0001, 8);
    check_gain("R3");
    commit(); exp_gain = 1; check_gain("R4");

    // Random words
    for (int k = 0; k < 24; k++) begin
      int w;
      w = $urandom & 255;
      shift_bits(16'(w), 8);
      check_gain("R3");
      commit();
      exp_gain = clamp59(w);
      check_gain("R4");
    end

    // Modes: R8, R9, R10
    shift_bits(16'h0017, 8); commit(); exp_gain = 23;
    tx_en = 1; pwr_up = 1; check_mode("R9", 1, 0, 0);
    tx_en = 0;             check_mode("R9", 0, 1, 0);
    check_gain("R10");
    pwr_up = 0; tx_en = 1; check_mode("R8", 0, 0, 1);
    tx_en = 0;             check_mode("R8", 0, 0, 1);
    check_gain("R10");
    pwr_up = 1; tx_en = 1; check_mode("R9", 1, 0, 0);
    check_gain("R10");
    for (int k = 0; k < 12; k++) begin
      bit p, t;
      p = 1'($urandom); t = 1'($urandom);
      pwr_up = p; tx_en = t;
      check_mode(p ? "R9" : "R8", p & t, p & ~t, ~p);
      chk("R11", $countones({st_active, st_txoff, st_sleep}), 1);
    end
    check_gain("R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule